// File: doc/BRIEF.md
# Parallel Video Scrambler with NRZI Encoder and Sync Detector

The block takes one 10-bit video character per clock, qualified by a valid input. It runs the character through a self-synchronizing scrambler with generator x^9 + x^4 + 1, then through an NRZ-to-NRZI encoder. It presents the ten encoded bits to a downstream serializer one clock later. All ten serial bit-steps of both stages are worked out combinationally inside one parallel clock. Bit 0 of the word goes first in serial order.

A bypass input lets characters leave unmodified. While bypass is active the scrambler history and the NRZI level stay frozen. Next to the data path, a detector looks for the timing-reference preamble 0x3FF, 0x000, 0x000 in consecutive valid input words. It raises a one-clock flag together with the output of the word that follows the preamble. A filter input can require that following word to carry its top bit, so that only plausible detections are reported. Sources that are 8 bits wide are placed in the upper eight bits with the two low bits zero.

Top module: `video_scrambler`

## Requirements
- R1: Synchronous reset (rst high at a rising edge) clears the 9-bit scrambler history, the NRZI level, out_data, out_valid and sync_flag to zero.
- R2: For each serial bit n of a valid, non-bypassed word, the scrambled bit is s[n] = d[n] XOR s[n-4] XOR s[n-9]. The history carries across word boundaries.
- R3: The NRZI level toggles on each scrambled 1 and holds on each 0: q[n] = q[n-1] XOR s[n]. The level is carried across words.
- R4: in_data[0] is the first serial bit, and out_data[i] is the NRZI level after serial bit i. out_valid and out_data follow an accepted word by exactly one clock. From the reset state, input 0x001 gives 0x10F.
- R5: With bypass high on a valid word, out_data equals in_data one clock later, and the scrambler history and NRZI level are unchanged.
- R6: When in_valid is low, out_valid is low the next clock, out_data holds, the encoder state is unchanged, and the word does not take part in sync detection.
- R7: After the valid words 0x3FF, 0x000, 0x000 in that order (invalid cycles between them allowed), sync_flag is high for one clock in the same cycle as out_valid for the next valid word.
- R8: With sync_filter high, a detection is reported only if that following word has bit 9 set. With sync_filter low, any following word is reported.
- R9: A preamble broken by any other valid word gives no flag. A new 0x3FF restarts the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies in_data for this clock |
| in_data | input | 10 | Input character, bit 0 first in serial order |
| bypass | input | 1 | Pass characters raw and freeze the encoder state |
| sync_filter | input | 1 | Require bit 9 of the word after a preamble |
| out_valid | output | 1 | out_data holds a new character |
| out_data | output | 10 | Encoded (or raw) character for the serializer |
| sync_flag | output | 1 | Preamble detected, aligned with the following word |

## Verification
All-zero words from reset must stay zero, which exposes any stray inversion or seeded state. A single 1 at bit 0 followed by zeros gives 0x10F and then a known echo pattern, which pins the tap positions at 4 and 9, the bit order and the carrying of state across words. A long varied word sequence with bypassed and invalid words mixed in is compared against a serial bit-by-bit model, which separates a state that truly freezes from one that advances. Sync sequences are sent intact, with gaps, broken, with a repeated 0x3FF, and with the filter on and off, which separates correct alignment and qualification from early, late or unqualified flags.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
    localparam int WORD_W = 10;
    localparam int TAP_A  = 4;
    localparam int TAP_B  = 9;
    localparam int HIST_W = TAP_B;

    localparam logic [WORD_W-1:0] PRE_ONES  = '1;
    localparam logic [WORD_W-1:0] PRE_ZEROS = '0;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HIST_W-1:0] hist_t;

    typedef struct packed {
        word_t line;
        hist_t hist;
        logic  level;
    } enc_t;

    typedef enum logic [1:0] {
        SEEK     = 2'd0,
        SAW_ONES = 2'd1,
        SAW_Z1   = 2'd2,
        SAW_Z2   = 2'd3
    } pre_state_e;

    // Ten serial steps of scrambler then NRZI; hist[0] is the newest bit.
    function automatic enc_t encode_word(word_t d, hist_t h, logic lvl);
        enc_t  r;
        hist_t hh;
        logic  l;
        logic  s;
        r  = '0;
        hh = h;
        l  = lvl;
        for (int i = 0; i < WORD_W; i++) begin
            s         = d[i] ^ hh[TAP_A-1] ^ hh[TAP_B-1];
            hh        = {hh[HIST_W-2:0], s};
            l         = l ^ s;
            r.line[i] = l;
        end
        r.hist  = hh;
        r.level = l;
        return r;
    endfunction
endpackage

// File: rtl/vsc_scram_nrzi.sv
module vsc_scram_nrzi
    import vsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  valid,
    input  logic  bypass,
    input  word_t word,
    output word_t line
);
    hist_t hist_q;
    logic  level_q;
    enc_t  enc;
    logic  advance;

    assign advance = valid && !bypass;

    always_comb begin
        enc  = encode_word(word, hist_q, level_q);
        line = enc.line;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q  <= '0;
            level_q <= 1'b0;
        end else if (advance) begin
            hist_q  <= enc.hist;
            level_q <= enc.level;
        end
    end

    // R5 R6
    state_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid || bypass) |=> ($stable(hist_q) && $stable(level_q)));

    // R3
    level_link_chk: assert property (@(posedge clk) disable iff (rst)
        advance |=> (level_q == $past(line[WORD_W-1])));
endmodule

// File: rtl/vsc_pre_detect.sv
module vsc_pre_detect
    import vsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  valid,
    input  logic  filter,
    input  word_t word,
    output logic  hit
);
    pre_state_e st_q, st_d;

    always_comb begin
        if (word == PRE_ONES)
            st_d = SAW_ONES;
        else if (word == PRE_ZEROS && st_q == SAW_ONES)
            st_d = SAW_Z1;
        else if (word == PRE_ZEROS && st_q == SAW_Z1)
            st_d = SAW_Z2;
        else
            st_d = SEEK;
    end

    assign hit = valid && (st_q == SAW_Z2) && (!filter || word[WORD_W-1]);

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= SEEK;
        else if (valid)
            st_q <= st_d;
    end

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && word == PRE_ONES) |=> (st_q == SAW_ONES));
endmodule

// File: rtl/video_scrambler.sv
module video_scrambler
    import vsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              bypass,
    input  logic              sync_filter,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              sync_flag
);
    word_t enc_line;
    logic  pre_hit;

    vsc_scram_nrzi enc_u (
        .clk    (clk),
        .rst    (rst),
        .valid  (in_valid),
        .bypass (bypass),
        .word   (in_data),
        .line   (enc_line)
    );

    vsc_pre_detect det_u (
        .clk    (clk),
        .rst    (rst),
        .valid  (in_valid),
        .filter (sync_filter),
        .word   (in_data),
        .hit    (pre_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            sync_flag <= 1'b0;
        end else begin
            out_valid <= in_valid;
            sync_flag <= pre_hit;
            if (in_valid)
                out_data <= bypass ? in_data : enc_line;
        end
    end

    // R4
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data)));

    // R5
    raw_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bypass) |=> (out_data == $past(in_data)));

    // R7
    flag_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        sync_flag |-> out_valid);

    // R8
    filter_qual_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_flag && $past(sync_filter)) |-> $past(in_data[WORD_W-1]));
endmodule

// File: tb/video_scrambler_tb.sv
module video_scrambler_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [9:0] in_data;
    logic       bypass;
    logic       sync_filter;
    logic       out_valid;
    logic [9:0] out_data;
    logic       sync_flag;

    int checks = 0;
    int failures = 0;

    // independent serial model
    logic [8:0] m_hist;
    logic       m_level;
    logic [9:0] m_out;
    int         m_prog;

    always #4 clk = ~clk;

    video_scrambler dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .bypass(bypass), .sync_filter(sync_filter), .out_valid(out_valid),
        .out_data(out_data), .sync_flag(sync_flag)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_hist = '0; m_level = 1'b0; m_out = '0; m_prog = 0;
    endtask

    // one clock: drive, let the edge pass, compare at the next falling edge
    task automatic step(input bit v, input logic [9:0] d, input bit byp,
                        input bit filt, input string tag);
        bit         e_flag;
        logic       s;
        logic [9:0] e_out;
        in_valid = v; in_data = d; bypass = byp; sync_filter = filt;
        e_flag = 1'b0;
        e_out  = m_out;
        if (v) begin
            e_flag = (m_prog == 3) && (!filt || d[9]);
            if (d == 10'h3FF) m_prog = 1;
            else if (d == 10'h000 && m_prog == 1) m_prog = 2;
            else if (d == 10'h000 && m_prog == 2) m_prog = 3;
            else m_prog = 0;
            if (byp) e_out = d;
            else begin
                for (int b = 0; b < 10; b++) begin
                    s = d[b] ^ m_hist[3] ^ m_hist[8];
                    m_hist = {m_hist[7:0], s};
                    if (s) m_level = ~m_level;
                    e_out[b] = m_level;
                end
            end
        end
        m_out = e_out;
        @(negedge clk);
        chk(out_valid == v, {tag, " out_valid"}, out_valid, v);
        chk(out_data == e_out, {tag, " out_data"}, out_data, e_out);
        chk(sync_flag == e_flag, {tag, " sync_flag"}, sync_flag, e_flag);
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1; in_valid = 1'b0; in_data = '0; bypass = 1'b0; sync_filter = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        chk(out_valid == 1'b0, {tag, " reset out_valid"}, out_valid, 0);
        chk(out_data == 10'h000, {tag, " reset out_data"}, out_data, 0);
        chk(sync_flag == 1'b0, {tag, " reset sync_flag"}, sync_flag, 0);
        rst = 1'b0;
    endtask

    task automatic t_zeros();   // R2 R3: zero in from zero state stays zero
        for (int i = 0; i < 4; i++) step(1, 10'h000, 0, 0, "R2 zeros");
    endtask

    task automatic t_impulse(); // R4 bit order and R2 tap echoes
        do_reset("R1");
        step(1, 10'h001, 0, 0, "R4 impulse");
        chk(out_data == 10'h10F, "R4 impulse literal", out_data, 10'h10F);
        for (int i = 0; i < 5; i++) step(1, 10'h000, 0, 0, "R2 echo");
    endtask

    task automatic t_pattern(); // R2 R3 varied words
        logic [9:0] w;
        w = 10'h2A5;
        for (int i = 0; i < 40; i++) begin
            w = {w[8:0], w[9] ^ w[6]} ^ 10'(i * 37);
            step(1, w, 0, 0, "R3 pattern");
        end
        step(1, 10'h2AA, 0, 0, "R3 alt");
        step(1, 10'h155, 0, 0, "R3 alt");
    endtask

    task automatic t_bypass();  // R5
        step(1, 10'h1C3, 1, 0, "R5 raw");
        step(1, 10'h3FE, 1, 0, "R5 raw");
        step(1, 10'h001, 1, 0, "R5 raw");
        for (int i = 0; i < 4; i++) step(1, 10'(i * 91 + 3), 0, 0, "R5 resume");
    endtask

    task automatic t_gap();     // R6
        step(1, 10'h0F0, 0, 0, "R6 pre");
        step(0, 10'h3FF, 0, 0, "R6 idle");
        step(0, 10'h123, 0, 0, "R6 idle");
        step(1, 10'h00F, 0, 0, "R6 after");
        step(1, 10'h3FF, 0, 0, "R6 pre gap");
        step(0, 10'h3FF, 0, 0, "R6 idle");
        step(1, 10'h000, 0, 0, "R6 pre gap");
        step(0, 10'h0AA, 0, 0, "R6 idle");
        step(1, 10'h000, 0, 0, "R6 pre gap");
        step(1, 10'h274, 0, 0, "R6 R7 gapped hit");
    endtask

    task automatic t_sync();    // R7 R8
        step(1, 10'h3FF, 0, 0, "R7 pre");
        step(1, 10'h000, 0, 0, "R7 pre");
        step(1, 10'h000, 0, 0, "R7 pre");
        step(1, 10'h080, 0, 0, "R7 unfiltered hit");
        chk(sync_flag == 1'b1, "R7 flag literal", sync_flag, 1);
        step(1, 10'h200, 0, 0, "R7 single pulse");
        chk(sync_flag == 1'b0, "R7 pulse ends", sync_flag, 0);
        step(1, 10'h3FF, 0, 1, "R8 pre");
        step(1, 10'h000, 0, 1, "R8 pre");
        step(1, 10'h000, 0, 1, "R8 pre");
        step(1, 10'h080, 0, 1, "R8 rejected");
        chk(sync_flag == 1'b0, "R8 reject literal", sync_flag, 0);
        step(1, 10'h3FF, 0, 1, "R8 pre");
        step(1, 10'h000, 0, 1, "R8 pre");
        step(1, 10'h000, 0, 1, "R8 pre");
        step(1, 10'h274, 0, 1, "R8 accepted");
        chk(sync_flag == 1'b1, "R8 accept literal", sync_flag, 1);
    endtask

    task automatic t_broken();  // R9
        step(1, 10'h3FF, 0, 0, "R9 pre");
        step(1, 10'h000, 0, 0, "R9 pre");
        step(1, 10'h111, 0, 0, "R9 break");
        step(1, 10'h000, 0, 0, "R9 pre");
        step(1, 10'h2F0, 0, 0, "R9 no hit");
        chk(sync_flag == 1'b0, "R9 no flag literal", sync_flag, 0);
        step(1, 10'h3FF, 0, 0, "R9 restart");
        step(1, 10'h3FF, 0, 0, "R9 restart");
        step(1, 10'h000, 0, 0, "R9 restart");
        step(1, 10'h000, 0, 0, "R9 restart");
        step(1, 10'h3A0, 0, 0, "R9 restart hit");
        chk(sync_flag == 1'b1, "R9 restart literal", sync_flag, 1);
    endtask

    task automatic t_reset_mid(); // R1
        step(1, 10'h1B7, 0, 0, "R1 dirty");
        do_reset("R1 mid");
        step(1, 10'h001, 0, 0, "R1 clean");
        chk(out_data == 10'h10F, "R1 history cleared", out_data, 10'h10F);
    endtask

    initial begin
        do_reset("R1");
        t_zeros();
        t_impulse();
        t_pattern();
        t_bypass();
        t_gap();
        t_sync();
        t_broken();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule